// File: doc/BRIEF.md
# Quadrature Counter/Timer Channel

One channel of a general-purpose 24-bit counter/timer. It is controlled through a word-wide register port. The count can advance from a quadrature encoder (phases A and B, plus an index line), with x1, x2 or x4 edge resolution, or from an internal tick. It counts up or down. The direction comes either from the encoder phase order or from a mode bit.

Two 24-bit preload values are held. They are written through the same low/high word pair, and a mode bit chooses which one receives the writes. The count can be reloaded in four ways:
- by software command;
- on the rising edge of the index line;
- on terminal count, which gives a retriggerable one-shot;
- on terminal count with alternating preload values, which gives a pulse train.

A capture flag named RCAP is set or toggled at terminal count and drives the output pin, with optional inversion. The flag can also serve as the hardware count-enable source. Reads are kept coherent by a 24-bit snapshot. The snapshot is taken either when the low word is read or on the rising edge of the index line.

Top module: `qcnt_channel`

## Requirements
- R1: After reset the count is 0, the mode word is 0x0000 and RCAP is 1, so `cnt_out` is 1.
- R2: Register map:
  - Address 0 is the low preload word on write and the low count word on read.
  - Address 1 is the high preload word. Only bits 7:0 of a write are kept, as count bits 23:16.
  - Address 2 is the mode word and reads back as written.
  - Address 3 is the command word and reads as 0.
  - Preload writes go to preload 0 when mode bit 14 is 0 and to preload 1 when it is 1.
- R3: A command word with bit 15 set clears the count. A command word with bit 14 set loads the count from preload 0, and this wins over bit 15. Bit 3 clears RCAP. In a cycle with a command write, no other count or RCAP update takes place.
- R4: Mode bits 8:7 select the enable: 0 disabled, 1 always enabled, 2 or 3 hardware. The hardware source is chosen by bits 6:5: 0 index high, 1 index low, 2 RCAP set, 3 RCAP clear. A disabled counter ignores count events.
- R5: Mode bits 10:9 select the clock. Value 2 is the internal tick: one step per cycle in which `tick_in` is high. Values 0, 1 and 3 select quadrature x1, x2 and x4.
- R6: Quadrature decoding:
  - A leading B ({A,B} going 00→10→11→01→00) is the up direction.
  - x4 steps on every valid edge, x2 on every edge of A, x1 on rising edges of A only.
  - A change of both phases at once is ignored.
  - The A, B and index inputs pass through two synchronizer stages.
- R7: Mode bit 12 = 0 takes the direction from the encoder phase order (the internal tick then counts up). Bit 12 = 1 takes it from bit 11, where 0 is up and 1 is down.
- R8: Mode bit 13 chooses the latch behaviour.
  - Bit 13 = 0: a low-word read returns the live count and snapshots all 24 bits; a high-word read returns snapshot bits 23:16 in bits 7:0, with bits 15:8 zero.
  - Bit 13 = 1: the snapshot is taken on the rising edge of the index line, and both words read the snapshot.
- R9: Terminal count is a down step taken while the count is 1. It normally clears the count and sets RCAP. With reload field bits 4:2 = 1 (one-shot), it loads preload 0 instead and sets RCAP.
- R10: With reload field = 2 (pulse train), terminal count alternates. When RCAP is 0 it loads preload 1 and sets RCAP; when RCAP is 1 it loads preload 0 and clears RCAP. This gives a low time of preload 0 counts and a high time of preload 1 counts.
- R11: With reload field = 4, a rising edge of the index line loads preload 0, taking priority over a count step. With any other value, the index line never reloads the count.
- R12: Mode bit 0 selects the output source: 0 is RCAP, 1 is a one-cycle strobe following each terminal count. Mode bit 1 inverts the pin.
- R13: The count wraps modulo 2^24 in both directions. A down step from 0 gives 0xFFFFFF and is not a terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (takes the snapshot on low-word reads) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Encoder index |
| tick_in | input | 1 | Internal count tick |
| cnt_out | output | 1 | Counter output pin |

## Verification
The checker assumes that a command write is the only bus operation in its cycle, and that preload 0 is not rewritten in that same cycle. Its load check relates the count to the preload value of the command cycle. The stimulus issues one register access at a time, always between clock edges. It holds every encoder and index level for four cycles, so that each synchronized transition reaches the decoder alone. The encoder sweeps return to state 00 before the count is read, and the tick is held low while mode or preload words are changed.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
  localparam int BUS_W = 16;

  typedef struct packed {
    logic       rsvd;
    logic       pr_sel;
    logic       latch_ctl;
    logic       dir_ctl;
    logic       dir_sw;
    logic [1:0] clk_src;
    logic [1:0] en_ctl;
    logic [1:0] hw_src;
    logic [2:0] reload;
    logic       out_pol;
    logic       out_src;
  } mode_t;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  localparam logic [1:0] CLK_X1  = 2'd0;
  localparam logic [1:0] CLK_X2  = 2'd1;
  localparam logic [1:0] CLK_INT = 2'd2;
  localparam logic [1:0] CLK_X4  = 2'd3;

  localparam logic [2:0] RL_ONESHOT = 3'd1;
  localparam logic [2:0] RL_TRAIN   = 3'd2;
  localparam logic [2:0] RL_INDEX   = 3'd4;

  localparam int CMD_RESET_BIT = 15;
  localparam int CMD_LOAD_BIT  = 14;
  localparam int CMD_RCAP_BIT  = 3;
endpackage

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  // chain[0] is the first stage; chain[STAGES] holds the previous synced value
  logic [STAGES:0][W-1:0] chain_q;
  logic [STAGES:0][W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q      = chain_q[STAGES-1];
  assign q_prev = chain_q[STAGES];
endmodule

// File: rtl/qcnt_quad.sv
module qcnt_quad
  import qcnt_pkg::*;
(
  input  logic [1:0] ab_cur,
  input  logic [1:0] ab_prev,
  input  logic [1:0] clk_src,
  output logic       step,
  output logic       up
);
  // phase position: 00->0, 10->1, 11->2, 01->3 (bit1 = B, bit0 = A^B)
  logic [1:0] pos_cur, pos_prev, diff;
  logic       valid, a_chg, a_rise;

  always_comb begin
    pos_cur  = {ab_cur[0],  ab_cur[1]  ^ ab_cur[0]};
    pos_prev = {ab_prev[0], ab_prev[1] ^ ab_prev[0]};
    diff     = pos_cur - pos_prev;
    valid    = (diff == 2'd1) || (diff == 2'd3);
    up       = (diff == 2'd1);
    a_chg    = ab_cur[1] ^ ab_prev[1];
    a_rise   = ab_cur[1] & ~ab_prev[1];
    case (clk_src)
      CLK_X1:  step = valid & a_rise;
      CLK_X2:  step = valid & a_chg;
      CLK_X4:  step = valid;
      default: step = 1'b0;
    endcase
  end
endmodule

// File: rtl/qcnt_regs.sv
module qcnt_regs
  import qcnt_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0] count,
  input  logic             idx_rise,
  output mode_t            mode,
  output logic [CNT_W-1:0] pr0,
  output logic [CNT_W-1:0] pr1,
  output logic             cmd_reset,
  output logic             cmd_load,
  output logic             cmd_rcap
);
  localparam int HI_W  = CNT_W - BUS_W;
  localparam int PAD_W = BUS_W - HI_W;

  mode_t            mode_q, mode_d;
  logic [CNT_W-1:0] pr0_q, pr0_d, pr1_q, pr1_d, snap_q, snap_d;
  logic             wr_lo, wr_hi, wr_mode, wr_cmd, rd_lo;

  always_comb begin
    wr_lo   = bus_we && (bus_addr == ADDR_LO);
    wr_hi   = bus_we && (bus_addr == ADDR_HI);
    wr_mode = bus_we && (bus_addr == ADDR_MODE);
    wr_cmd  = bus_we && (bus_addr == ADDR_CMD);
    rd_lo   = bus_re && (bus_addr == ADDR_LO);

    mode_d = mode_q;
    pr0_d  = pr0_q;
    pr1_d  = pr1_q;
    snap_d = snap_q;
    if (wr_mode) mode_d = mode_t'(bus_wdata);
    if (wr_lo) begin
      if (mode_q.pr_sel) pr1_d[BUS_W-1:0] = bus_wdata;
      else               pr0_d[BUS_W-1:0] = bus_wdata;
    end
    if (wr_hi) begin
      if (mode_q.pr_sel) pr1_d[CNT_W-1:BUS_W] = bus_wdata[HI_W-1:0];
      else               pr0_d[CNT_W-1:BUS_W] = bus_wdata[HI_W-1:0];
    end
    if (mode_q.latch_ctl) begin
      if (idx_rise) snap_d = count;
    end else if (rd_lo) begin
      snap_d = count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      pr0_q  <= '0;
      pr1_q  <= '0;
      snap_q <= '0;
    end else begin
      mode_q <= mode_d;
      pr0_q  <= pr0_d;
      pr1_q  <= pr1_d;
      snap_q <= snap_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_LO:   bus_rdata = mode_q.latch_ctl ? snap_q[BUS_W-1:0] : count[BUS_W-1:0];
      ADDR_HI:   bus_rdata = {{PAD_W{1'b0}}, snap_q[CNT_W-1:BUS_W]};
      ADDR_MODE: bus_rdata = mode_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign mode      = mode_q;
  assign pr0       = pr0_q;
  assign pr1       = pr1_q;
  assign cmd_reset = wr_cmd && bus_wdata[CMD_RESET_BIT];
  assign cmd_load  = wr_cmd && bus_wdata[CMD_LOAD_BIT];
  assign cmd_rcap  = wr_cmd && bus_wdata[CMD_RCAP_BIT];
endmodule

// File: rtl/qcnt_channel.sv
module qcnt_channel
  import qcnt_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [1:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             enc_idx,
  input  logic             tick_in,
  output logic             cnt_out
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [2:0]       syn_q, syn_prev;
  logic             idx_lvl, idx_rise;
  logic             q_step, q_up;
  mode_t            mode;
  logic [CNT_W-1:0] pr0, pr1;
  logic             cmd_reset, cmd_load, cmd_rcap;
  logic [CNT_W-1:0] count_q, count_d;
  logic             rcap_q, rcap_d, tc_q, tc_d;
  logic             step, up, en, adv, tc;

  qcnt_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({enc_a, enc_b, enc_idx}),
    .q(syn_q), .q_prev(syn_prev)
  );

  assign idx_lvl  = syn_q[0];
  assign idx_rise = syn_q[0] & ~syn_prev[0];

  qcnt_quad u_quad (
    .ab_cur(syn_q[2:1]), .ab_prev(syn_prev[2:1]), .clk_src(mode.clk_src),
    .step(q_step), .up(q_up)
  );

  qcnt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count_q), .idx_rise(idx_rise), .mode(mode), .pr0(pr0), .pr1(pr1),
    .cmd_reset(cmd_reset), .cmd_load(cmd_load), .cmd_rcap(cmd_rcap)
  );

  // event qualification
  always_comb begin
    step = (mode.clk_src == CLK_INT) ? tick_in : q_step;
    if (mode.dir_ctl)                    up = ~mode.dir_sw;
    else if (mode.clk_src == CLK_INT)    up = 1'b1;
    else                                 up = q_up;
    case (mode.en_ctl)
      2'd0: en = 1'b0;
      2'd1: en = 1'b1;
      default: begin
        case (mode.hw_src)
          2'd0:    en = idx_lvl;
          2'd1:    en = ~idx_lvl;
          2'd2:    en = rcap_q;
          default: en = ~rcap_q;
        endcase
      end
    endcase
    adv = step & en;
    tc  = adv & ~up & (count_q == CNT_ONE);
  end

  // next state: command > index reload > count step
  always_comb begin
    count_d = count_q;
    rcap_d  = rcap_q;
    tc_d    = 1'b0;
    if (cmd_reset || cmd_load || cmd_rcap) begin
      if (cmd_reset) count_d = '0;
      if (cmd_load)  count_d = pr0;
      if (cmd_rcap)  rcap_d  = 1'b0;
    end else if ((mode.reload == RL_INDEX) && idx_rise) begin
      count_d = pr0;
    end else if (adv) begin
      if (tc) begin
        tc_d = 1'b1;
        case (mode.reload)
          RL_ONESHOT: begin count_d = pr0; rcap_d = 1'b1; end
          RL_TRAIN:   begin count_d = rcap_q ? pr0 : pr1; rcap_d = ~rcap_q; end
          default:    begin count_d = '0; rcap_d = 1'b1; end
        endcase
      end else begin
        count_d = up ? count_q + CNT_ONE : count_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      rcap_q  <= 1'b1;
      tc_q    <= 1'b0;
    end else begin
      count_q <= count_d;
      rcap_q  <= rcap_d;
      tc_q    <= tc_d;
    end
  end

  assign cnt_out = (mode.out_src ? tc_q : rcap_q) ^ mode.out_pol;
endmodule

// File: rtl/qcnt_channel_chk.sv
module qcnt_channel_chk
  import qcnt_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [1:0]       bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic [BUS_W-1:0] bus_rdata,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] pr0,
  input logic             rcap_q,
  input logic [BUS_W-1:0] mode
);
  localparam int HI_W = CNT_W - BUS_W;

  logic cmd_wr;
  assign cmd_wr = bus_we && (bus_addr == ADDR_CMD);

  // R3
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[CMD_RESET_BIT] && !bus_wdata[CMD_LOAD_BIT]) |=> (count_q == '0))
    else $error("reset command did not clear count");

  // R3
  load_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[CMD_LOAD_BIT]) |=> (count_q == $past(pr0)))
    else $error("load command did not copy preload 0");

  // R3
  rcap_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[CMD_RCAP_BIT]) |=> !rcap_q)
    else $error("RCAP not cleared by command");

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode[8:7] == 2'd0) && !cmd_wr && (mode[4:2] != RL_INDEX)) |=> $stable(count_q))
    else $error("disabled counter moved");

  // R8
  hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_HI) |-> (bus_rdata[BUS_W-1:HI_W] == '0))
    else $error("high word upper bits not zero");

  // R2
  cmd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_CMD) |-> (bus_rdata == '0))
    else $error("command address read non-zero");
endmodule

bind qcnt_channel qcnt_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_q(count_q),
  .pr0(pr0), .rcap_q(rcap_q), .mode(mode)
);

// File: tb/qcnt_channel_tb.sv
module qcnt_channel_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, bus_we, bus_re, enc_a, enc_b, enc_idx, tick_in;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        cnt_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] mode_w;

  qcnt_channel u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx), .tick_in(tick_in),
    .cnt_out(cnt_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(int osrc, int pol, int rl, int hw, int en,
                                     int cs, int dir, int dctl, int lat);
    logic [2:0] r; logic [1:0] h, e, c;
    r = rl[2:0]; h = hw[1:0]; e = en[1:0]; c = cs[1:0];
    return {1'b0, 1'b0, lat[0], dctl[0], dir[0], c, e, h, r, pol[0], osrc[0]};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic set_mode(input logic [15:0] v);
    mode_w = v;
    wr(2'd2, v);
  endtask

  task automatic preload(input bit sel, input logic [23:0] v);
    wr(2'd2, {mode_w[15], sel, mode_w[13:0]});
    wr(2'd1, {8'h00, v[23:16]});
    wr(2'd0, v[15:0]);
    wr(2'd2, mode_w);
  endtask

  task automatic rd_lo(output logic [15:0] v);
    @(negedge clk);
    bus_addr = 2'd0; bus_re = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic rd_hi(output logic [15:0] v);
    @(negedge clk);
    bus_addr = 2'd1;
    #1 v = bus_rdata;
  endtask

  task automatic rd_at(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic rd24(output logic [23:0] v);
    logic [15:0] lo, hi;
    rd_lo(lo);
    rd_hi(hi);
    v = {hi[7:0], lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
  endtask

  task automatic qset(input bit a, input bit b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic idx_set(input bit v);
    @(negedge clk);
    enc_idx = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_run(input logic [15:0] cmd, output int highs);
    highs = 0;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = cmd;
    @(negedge clk);
    bus_we = 1'b0; tick_in = 1'b1;
    for (int i = 0; i < 20; i++) begin
      #1 highs += int'(cnt_out);
      @(negedge clk);
    end
    tick_in = 1'b0;
  endtask

  logic [23:0] v24;
  logic [15:0] v16;
  int          nh;
  logic [1:0]  qtab [4];

  initial begin
    qtab[0] = 2'b00; qtab[1] = 2'b10; qtab[2] = 2'b11; qtab[3] = 2'b01;
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    enc_a = 1'b0; enc_b = 1'b0; enc_idx = 1'b0; tick_in = 1'b0; mode_w = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd24(v24);            chk("R1 count", 32'(v24), 32'h0);
    rd_at(2'd2, v16);     chk("R1 mode", 32'(v16), 32'h0);
    chk("R1 out", 32'(cnt_out), 32'h1);
    rd_at(2'd3, v16);     chk("R2 cmd read", 32'(v16), 32'h0);

    // register map and preload selection
    wr(2'd2, 16'h4000);
    rd_at(2'd2, v16);     chk("R2 mode readback", 32'(v16), 32'h4000);
    wr(2'd1, 16'h0000); wr(2'd0, 16'h00AB);
    set_mode(16'h0000);
    wr(2'd1, 16'hAB12); wr(2'd0, 16'h3456);
    wr(2'd3, 16'h4000);
    rd24(v24);            chk("R2 preload0 load", 32'(v24), 32'h123456);
    wr(2'd3, 16'h8000);
    rd24(v24);            chk("R3 reset cmd", 32'(v24), 32'h0);
    wr(2'd3, 16'hC000);
    rd24(v24);            chk("R3 load wins", 32'(v24), 32'h123456);

    // internal tick, direction, enable, wrap
    set_mode(mk(0,0,0,0,1,2,0,1,0));
    wr(2'd3, 16'h8000);
    ticks(7);  rd24(v24); chk("R5 tick up", 32'(v24), 32'd7);
    set_mode(mk(0,0,0,0,1,2,1,1,0));
    ticks(3);  rd24(v24); chk("R7 tick down", 32'(v24), 32'd4);
    set_mode(mk(0,0,0,0,0,2,1,1,0));
    ticks(5);  rd24(v24); chk("R4 disabled", 32'(v24), 32'd4);
    set_mode(mk(0,0,0,0,1,2,1,1,0));
    wr(2'd3, 16'h8000);
    ticks(1);  rd24(v24); chk("R13 wrap down", 32'(v24), 32'hFFFFFF);
    chk("R13 no tc out", 32'(cnt_out), 32'h1);
    set_mode(mk(0,0,0,0,1,2,0,1,0));
    ticks(1);  rd24(v24); chk("R13 wrap up", 32'(v24), 32'h0);

    // hardware enable from index level
    set_mode(mk(0,0,0,0,2,2,0,1,0));
    ticks(4);  rd24(v24); chk("R4 hw idx low", 32'(v24), 32'd0);
    idx_set(1'b1);
    ticks(4);  rd24(v24); chk("R4 hw idx high", 32'(v24), 32'd4);
    set_mode(mk(0,0,0,1,2,2,0,1,0));
    ticks(4);  rd24(v24); chk("R4 hw not idx", 32'(v24), 32'd4);
    idx_set(1'b0);

    // quadrature sweep: x1, x2, x4, both directions
    for (int m = 0; m < 3; m++) begin
      for (int dn = 0; dn < 2; dn++) begin
        int cs, f, p;
        logic [23:0] exp;
        cs = (m == 0) ? 0 : (m == 1) ? 1 : 3;
        f  = (m == 0) ? 1 : (m == 1) ? 2 : 4;
        set_mode(mk(0,0,0,0,1,cs,0,0,0));
        wr(2'd3, 16'h8000);
        p = 0;
        for (int s = 0; s < 12; s++) begin
          p = dn ? (p + 3) % 4 : (p + 1) % 4;
          qset(qtab[p][1], qtab[p][0]);
        end
        exp = dn ? 24'(0 - 3*f) : 24'(3*f);
        rd24(v24);
        chk(dn ? "R6 R7 quad down" : "R6 quad up", 32'(v24), 32'(exp));
      end
    end
    set_mode(mk(0,0,0,0,1,3,0,0,0));
    wr(2'd3, 16'h8000);
    qset(1'b1, 1'b1); qset(1'b0, 1'b0);
    rd24(v24);            chk("R6 invalid ignored", 32'(v24), 32'h0);
    set_mode(mk(0,0,0,0,1,3,1,1,0));
    for (int s = 1; s <= 4; s++) qset(qtab[s%4][1], qtab[s%4][0]);
    rd24(v24);            chk("R7 sw dir overrides", 32'(v24), 32'hFFFFFC);

    // latch behaviour
    set_mode(mk(0,0,0,0,1,2,0,1,0));
    preload(1'b0, 24'h00FFFF);
    wr(2'd3, 16'h4000);
    rd_lo(v16);           chk("R8 live low", 32'(v16), 32'hFFFF);
    ticks(1);
    rd_hi(v16);           chk("R8 snapshot high", 32'(v16), 32'h0000);
    rd24(v24);            chk("R8 new count", 32'(v24), 32'h010000);
    set_mode(mk(0,0,0,0,1,2,0,1,1));
    idx_set(1'b1); idx_set(1'b0);
    ticks(5);
    rd24(v24);            chk("R8 index snapshot", 32'(v24), 32'h010000);
    set_mode(mk(0,0,0,0,1,2,0,1,0));
    rd24(v24);            chk("R8 live after", 32'(v24), 32'h010005);

    // index reload
    set_mode(mk(0,0,4,0,0,2,0,1,0));
    preload(1'b0, 24'h000500);
    wr(2'd3, 16'h8000);
    idx_set(1'b1); idx_set(1'b0);
    rd24(v24);            chk("R11 index reload", 32'(v24), 32'h000500);
    set_mode(mk(0,0,0,0,0,2,0,1,0));
    wr(2'd3, 16'h8000);
    idx_set(1'b1); idx_set(1'b0);
    rd24(v24);            chk("R11 no index reload", 32'(v24), 32'h0);

    // one-shot, enabled while RCAP clear
    set_mode(mk(0,1,1,3,2,2,1,1,0));
    preload(1'b0, 24'd5);
    wr(2'd3, 16'h4000);
    chk("R12 inverted idle", 32'(cnt_out), 32'h0);
    ticks(3);  rd24(v24); chk("R4 not rcap holds", 32'(v24), 32'd5);
    pulse_run(16'h0008, nh);
    chk("R9 one-shot width", 32'(nh), 32'd5);
    rd24(v24);            chk("R9 reloaded", 32'(v24), 32'd5);
    chk("R9 rcap set", 32'(cnt_out), 32'h0);

    // pulse train
    set_mode(mk(0,0,2,0,1,2,1,1,0));
    preload(1'b0, 24'd3);
    preload(1'b1, 24'd2);
    pulse_run(16'h4008, nh);
    chk("R10 train high samples", 32'(nh), 32'd8);
    set_mode(mk(0,1,2,0,1,2,1,1,0));
    pulse_run(16'h4008, nh);
    chk("R12 train inverted", 32'(nh), 32'd12);
    set_mode(mk(1,0,2,0,1,2,1,1,0));
    pulse_run(16'h4008, nh);
    chk("R12 tc strobe", 32'(nh), 32'd7);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule